// File: doc/BRIEF.md
# Lockable System Control Register Bank

This block is a small bank of system-level control and status words reached over a plain 32-bit register bus inside a 4 KB address window. Software finds a fixed identification word here, together with an LED word, two general configuration words and two flag words. Each flag word has its own set address and clear address, so one write changes only the chosen bits. One flag word keeps its contents through a normal block reset because it has a separate reset input. A few status offsets return fixed constants. Offsets that are not defined read as zero.

A guarded reset-control word can request a board reset. Writes to that word take effect only while the 16-bit unlock key sits in the lock word. If bit 8 of an accepted value is set, the block drives a one-cycle reset-request pulse. Writing any value other than the key leaves bit 15 of the lock word at zero, and that locks the bank again.

The bus never stalls, so there is no back-pressure. A request is a single cycle with `bus_sel` high. Writes take effect at that clock edge. A read returns its word on `bus_rdata` in the next cycle, qualified by `bus_rvalid`, and the requester must take it in that cycle. A write to an offset that cannot be written is dropped and raises a one-cycle error strobe.

Top module: `syscfg_bank`

## Requirements
- R1: A read of byte offset 0x000 returns 0x41007004.
- R2: Offsets 0x008 (LED), 0x028 and 0x02C each hold a full 32-bit word that reads back as last written.
- R3: Writing exactly 0x0000A05F to offset 0x020 stores 0xA05F, and a read of 0x020 returns it. This opens the guard.
- R4: Writing any other 32-bit value to offset 0x020 stores only its bits 14:0, so bits 31:15 of the read-back value are 0 and the guard is closed.
- R5: A write to 0x030 ORs the data into the flag word, and a write to 0x034 clears the flag bits that are 1 in the data. A read of 0x030 returns the flag word.
- R6: The persistent flag word is set at 0x038, cleared at 0x03C and read at 0x038, with the same bit rules as R5.
- R7: A write to 0x040 updates the reset-control word only while the lock word holds 0xA05F. A read of 0x040 returns the last accepted value.
- R8: An accepted write to 0x040 with data bit 8 set drives `board_rst_req` high for exactly one cycle, the cycle after the write. A rejected write, or one with bit 8 clear, drives no pulse.
- R9: Offset 0x044 reads 0x00000001 and offset 0x050 reads 0x00001000. Offset 0x004, offset 0x034, every other undefined offset and every address that is not word-aligned read 0.
- R10: A write to any address other than 0x008, 0x020, 0x028, 0x02C, 0x030, 0x034, 0x038, 0x03C or 0x040 changes nothing and drives `bad_wr` high for one cycle, the cycle after. Writes to the listed addresses never raise `bad_wr`, and that includes a rejected write to 0x040.
- R11: While `rst_n` is low, every stored word is cleared to 0 except the persistent flags. Those are cleared only by `nv_rst_n`.
- R12: `bus_rvalid` is high in exactly the cycle after each read request and low in every other cycle, including the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for all words except the persistent flags |
| nv_rst_n | input | 1 | Active-low reset for the persistent flags only |
| bus_sel | input | 1 | Request strobe, one access per cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, the cycle after a read request |
| bad_wr | output | 1 | One-cycle strobe after a write to a non-writable address |
| board_rst_req | output | 1 | One-cycle board-reset request |

## Verification
Two things happen in the same cycle after an accepted reset-control write. The reset-request pulse is on its pin, and the next bus request is already being taken. The bench issues a read of the reset-control word right after a write that has bit 8 set. It checks that `board_rst_req` is high in the cycle that read is accepted, and that the returned word is the value just written, not the old one. A second overlap comes from the two resets: `rst_n` is pulsed alone, and the bench checks that every volatile word reads zero while the persistent flags keep their bits, until `nv_rst_n` is pulsed as well.

// File: rtl/syscfg_pkg.sv
package syscfg_pkg;

  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_ID      = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_SW      = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_LED     = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_LOCK    = 12'h020;
  localparam logic [ADDR_W-1:0] OFF_CFG1    = 12'h028;
  localparam logic [ADDR_W-1:0] OFF_CFG2    = 12'h02C;
  localparam logic [ADDR_W-1:0] OFF_FLG_SET = 12'h030;
  localparam logic [ADDR_W-1:0] OFF_FLG_CLR = 12'h034;
  localparam logic [ADDR_W-1:0] OFF_NV_SET  = 12'h038;
  localparam logic [ADDR_W-1:0] OFF_NV_CLR  = 12'h03C;
  localparam logic [ADDR_W-1:0] OFF_RSTCTL  = 12'h040;
  localparam logic [ADDR_W-1:0] OFF_PCI     = 12'h044;
  localparam logic [ADDR_W-1:0] OFF_LCD     = 12'h050;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_ID,
    SEL_SW,
    SEL_LED,
    SEL_LOCK,
    SEL_CFG1,
    SEL_CFG2,
    SEL_FLG_SET,
    SEL_FLG_CLR,
    SEL_NV_SET,
    SEL_NV_CLR,
    SEL_RSTCTL,
    SEL_PCI,
    SEL_LCD
  } reg_sel_e;

  localparam int unsigned N_PLAIN = 3;

  // Map a plain read/write word slot to its decoded select.
  function automatic reg_sel_e plain_sel(input int unsigned idx);
    case (idx)
      0:       return SEL_LED;
      1:       return SEL_CFG1;
      default: return SEL_CFG2;
    endcase
  endfunction

endpackage

// File: rtl/syscfg_decode.sv
module syscfg_decode
  import syscfg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              writable
);

  always_comb begin
    case (addr)
      OFF_ID:      sel = SEL_ID;
      OFF_SW:      sel = SEL_SW;
      OFF_LED:     sel = SEL_LED;
      OFF_LOCK:    sel = SEL_LOCK;
      OFF_CFG1:    sel = SEL_CFG1;
      OFF_CFG2:    sel = SEL_CFG2;
      OFF_FLG_SET: sel = SEL_FLG_SET;
      OFF_FLG_CLR: sel = SEL_FLG_CLR;
      OFF_NV_SET:  sel = SEL_NV_SET;
      OFF_NV_CLR:  sel = SEL_NV_CLR;
      OFF_RSTCTL:  sel = SEL_RSTCTL;
      OFF_PCI:     sel = SEL_PCI;
      OFF_LCD:     sel = SEL_LCD;
      default:     sel = SEL_NONE;
    endcase
  end

  always_comb begin
    case (sel)
      SEL_LED, SEL_LOCK, SEL_CFG1, SEL_CFG2,
      SEL_FLG_SET, SEL_FLG_CLR, SEL_NV_SET, SEL_NV_CLR,
      SEL_RSTCTL: writable = 1'b1;
      default:    writable = 1'b0;
    endcase
  end

endmodule

// File: rtl/syscfg_setclr.sv
module syscfg_setclr #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] bits,
  output logic [W-1:0] q
);

  logic [W-1:0] set_mask;
  logic [W-1:0] clr_mask;

  assign set_mask = set_en ? bits : '0;
  assign clr_mask = clr_en ? bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (set_en || clr_en) q <= (q | set_mask) & ~clr_mask;
  end

endmodule

// File: rtl/syscfg_lock.sv
module syscfg_lock #(
  parameter int unsigned        DATA_W   = 32,
  parameter int unsigned        KEY_W    = 16,
  parameter logic [KEY_W-1:0]   LOCK_KEY = 16'hA05F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [KEY_W-1:0]  lock_q,
  output logic              open
);

  localparam logic [DATA_W-1:0] KEY_WORD = {{(DATA_W-KEY_W){1'b0}}, LOCK_KEY};

  logic key_hit;
  assign key_hit = (wdata == KEY_WORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= '0;
    else if (wr_en) begin
      if (key_hit) lock_q <= LOCK_KEY;
      else         lock_q <= {1'b0, wdata[KEY_W-2:0]};
    end
  end

  assign open = (lock_q == LOCK_KEY);

endmodule

// File: rtl/syscfg_bank.sv
module syscfg_bank
  import syscfg_pkg::*;
#(
  parameter int unsigned        DATA_W   = 32,
  parameter int unsigned        KEY_W    = 16,
  parameter logic [KEY_W-1:0]   LOCK_KEY = 16'hA05F,
  parameter logic [DATA_W-1:0]  ID_WORD  = 32'h41007004,
  parameter logic [DATA_W-1:0]  PCI_WORD = 32'h00000001,
  parameter logic [DATA_W-1:0]  LCD_WORD = 32'h00001000,
  parameter int unsigned        RST_BIT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nv_rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              bad_wr,
  output logic              board_rst_req
);

  logic wr_stb;
  logic rd_stb;
  assign wr_stb = bus_sel & bus_wr;
  assign rd_stb = bus_sel & ~bus_wr;

  reg_sel_e sel;
  logic     sel_writable;

  syscfg_decode u_dec (
    .addr     (bus_addr),
    .sel      (sel),
    .writable (sel_writable)
  );

  // Plain read/write words: LED and two configuration words.
  logic [DATA_W-1:0] plain_q [N_PLAIN];

  for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) plain_q[g] <= '0;
      else if (wr_stb && (sel == plain_sel(g))) plain_q[g] <= bus_wdata;
    end
  end

  // Flag words with separate set and clear addresses.
  logic [DATA_W-1:0] flg_q;
  logic [DATA_W-1:0] nv_q;

  syscfg_setclr #(.W(DATA_W)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (wr_stb && (sel == SEL_FLG_SET)),
    .clr_en (wr_stb && (sel == SEL_FLG_CLR)),
    .bits   (bus_wdata),
    .q      (flg_q)
  );

  syscfg_setclr #(.W(DATA_W)) u_nvflags (
    .clk    (clk),
    .rst_n  (nv_rst_n),
    .set_en (wr_stb && (sel == SEL_NV_SET)),
    .clr_en (wr_stb && (sel == SEL_NV_CLR)),
    .bits   (bus_wdata),
    .q      (nv_q)
  );

  // Key-protected lock word.
  logic [KEY_W-1:0] lock_q;
  logic             lock_open;

  syscfg_lock #(.DATA_W(DATA_W), .KEY_W(KEY_W), .LOCK_KEY(LOCK_KEY)) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_stb && (sel == SEL_LOCK)),
    .wdata  (bus_wdata),
    .lock_q (lock_q),
    .open   (lock_open)
  );

  // Guarded reset-control word and its request pulse.
  logic [DATA_W-1:0] rstctl_q;
  logic              rstctl_take;
  logic              rst_req_q;

  assign rstctl_take = wr_stb && (sel == SEL_RSTCTL) && lock_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rstctl_q  <= '0;
      rst_req_q <= 1'b0;
    end else begin
      if (rstctl_take) rstctl_q <= bus_wdata;
      rst_req_q <= rstctl_take && bus_wdata[RST_BIT];
    end
  end

  // Error strobe for dropped writes.
  logic bad_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bad_q <= 1'b0;
    else        bad_q <= wr_stb && !sel_writable;
  end

  // Read selection, registered for one cycle of latency.
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_ID:      rd_mux = ID_WORD;
      SEL_LED:     rd_mux = plain_q[0];
      SEL_CFG1:    rd_mux = plain_q[1];
      SEL_CFG2:    rd_mux = plain_q[2];
      SEL_LOCK:    rd_mux[KEY_W-1:0] = lock_q;
      SEL_FLG_SET: rd_mux = flg_q;
      SEL_NV_SET:  rd_mux = nv_q;
      SEL_RSTCTL:  rd_mux = rstctl_q;
      SEL_PCI:     rd_mux = PCI_WORD;
      SEL_LCD:     rd_mux = LCD_WORD;
      default:     rd_mux = '0;
    endcase
  end

  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_stb;
      rdata_q  <= rd_stb ? rd_mux : '0;
    end
  end

  assign bus_rdata     = rdata_q;
  assign bus_rvalid    = rvalid_q;
  assign bad_wr        = bad_q;
  assign board_rst_req = rst_req_q;

endmodule

// File: rtl/syscfg_bank_chk.sv
module syscfg_bank_chk
  import syscfg_pkg::*;
#(
  parameter int unsigned       DATA_W   = 32,
  parameter int unsigned       KEY_W    = 16,
  parameter logic [KEY_W-1:0]  LOCK_KEY = 16'hA05F,
  parameter logic [DATA_W-1:0] ID_WORD  = 32'h41007004,
  parameter logic [DATA_W-1:0] PCI_WORD = 32'h00000001,
  parameter int unsigned       RST_BIT  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic              bad_wr,
  input logic              board_rst_req,
  input logic [KEY_W-1:0]  lock_q,
  input logic              lock_open
);

  p_read_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> bus_rvalid);

  p_no_stray_rvalid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> !bus_rvalid);

  p_id_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && ($past(bus_addr) == OFF_ID)) |-> (bus_rdata == ID_WORD));

  p_pci_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && ($past(bus_addr) == OFF_PCI)) |-> (bus_rdata == PCI_WORD));

  p_key_bit_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q[KEY_W-1] |-> (lock_q == LOCK_KEY));

  p_rst_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    board_rst_req |-> $past(bus_sel && bus_wr && (bus_addr == OFF_RSTCTL)
                            && bus_wdata[RST_BIT] && lock_open));

  p_rst_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    board_rst_req |-> !$past(board_rst_req) || $past(bus_sel && bus_wr));

  p_bad_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |-> $past(bus_sel && bus_wr));

endmodule

bind syscfg_bank syscfg_bank_chk #(
  .DATA_W   (DATA_W),
  .KEY_W    (KEY_W),
  .LOCK_KEY (LOCK_KEY),
  .ID_WORD  (ID_WORD),
  .PCI_WORD (PCI_WORD),
  .RST_BIT  (RST_BIT)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_sel       (bus_sel),
  .bus_wr        (bus_wr),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .bus_rdata     (bus_rdata),
  .bus_rvalid    (bus_rvalid),
  .bad_wr        (bad_wr),
  .board_rst_req (board_rst_req),
  .lock_q        (lock_q),
  .lock_open     (lock_open)
);

// File: tb/tb_syscfg_bank.sv
`timescale 1ns/1ps
module tb_syscfg_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nv_rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        bad_wr;
  logic        board_rst_req;

  always #5 clk = ~clk;

  syscfg_bank dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .nv_rst_n      (nv_rst_n),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .bus_rvalid    (bus_rvalid),
    .bad_wr        (bad_wr),
    .board_rst_req (board_rst_req)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] value;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data as the design returns it.
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12 unexpected rvalid", bus_rdata, 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(bus_rdata == e.value, e.tag, bus_rdata, e.value);
      end
    end
  end

  // Driver: read request, expectation pushed to the scoreboard.
  task automatic rd(input logic [11:0] a, input logic [31:0] v, input string tag);
    exp_t e;
    e.value = v;
    e.tag   = tag;
    exp_q.push_back(e);
    bus_sel  = 1'b1;
    bus_wr   = 1'b0;
    bus_addr = a;
    @(negedge clk);
    bus_sel  = 1'b0;
  endtask

  // Driver: write, then check the strobes in the next two cycles.
  task automatic wr(input logic [11:0] a, input logic [31:0] d,
                    input bit exp_pulse, input bit exp_bad, input string tag);
    bus_sel   = 1'b1;
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0;
    bus_wr  = 1'b0;
    check(board_rst_req == exp_pulse, {tag, " R8 pulse"}, 32'(board_rst_req), 32'(exp_pulse));
    check(bad_wr == exp_bad, {tag, " R10 bad_wr"}, 32'(bad_wr), 32'(exp_bad));
    check(bus_rvalid == 1'b0, {tag, " R12 no rvalid on write"}, 32'(bus_rvalid), 32'h0);
    @(negedge clk);
    check(board_rst_req == 1'b0, {tag, " R8 pulse one cycle"}, 32'(board_rst_req), 32'h0);
    check(bad_wr == 1'b0, {tag, " R10 bad_wr one cycle"}, 32'(bad_wr), 32'h0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    nv_rst_n = 1'b1;
    idle(2);

    // Reset state and identification
    check(bus_rvalid == 1'b0 && bad_wr == 1'b0 && board_rst_req == 1'b0,
          "R11 reset outputs low", {29'b0, bus_rvalid, bad_wr, board_rst_req}, 32'h0);
    rd(12'h000, 32'h41007004, "R1 id word");
    rd(12'h008, 32'h0, "R11 led reset");
    rd(12'h020, 32'h0, "R11 lock reset");
    rd(12'h028, 32'h0, "R11 cfg1 reset");
    rd(12'h02C, 32'h0, "R11 cfg2 reset");
    rd(12'h030, 32'h0, "R11 flags reset");
    rd(12'h038, 32'h0, "R11 nv flags reset");
    rd(12'h040, 32'h0, "R11 rstctl reset");
    idle(1);

    // Plain words
    wr(12'h008, 32'h0000005A, 1'b0, 1'b0, "R2 led");
    wr(12'h028, 32'hDEADBEEF, 1'b0, 1'b0, "R2 cfg1");
    wr(12'h02C, 32'h12345678, 1'b0, 1'b0, "R2 cfg2");
    rd(12'h008, 32'h0000005A, "R2 led read");
    rd(12'h028, 32'hDEADBEEF, "R2 cfg1 read");
    rd(12'h02C, 32'h12345678, "R2 cfg2 read");

    // Flags with set/clear addresses
    wr(12'h030, 32'h0000000F, 1'b0, 1'b0, "R5 set a");
    wr(12'h030, 32'h800000F0, 1'b0, 1'b0, "R5 set b");
    rd(12'h030, 32'h800000FF, "R5 set or");
    wr(12'h034, 32'h8000003C, 1'b0, 1'b0, "R5 clr");
    rd(12'h030, 32'h000000C3, "R5 clear mask");
    rd(12'h034, 32'h0, "R9 clear address reads zero");
    wr(12'h038, 32'h00A50000, 1'b0, 1'b0, "R6 set a");
    wr(12'h038, 32'h00000011, 1'b0, 1'b0, "R6 set b");
    wr(12'h03C, 32'h00050001, 1'b0, 1'b0, "R6 clr");
    rd(12'h038, 32'h00A00010, "R6 nv flags");

    // Lock values other than the key
    wr(12'h020, 32'h00001234, 1'b0, 1'b0, "R4 lock plain");
    rd(12'h020, 32'h00001234, "R4 lock low bits");
    wr(12'h020, 32'hFFFFFFFF, 1'b0, 1'b0, "R4 lock ones");
    rd(12'h020, 32'h00007FFF, "R4 bit15 cleared");
    wr(12'h020, 32'h0001A05F, 1'b0, 1'b0, "R4 key with high bit");
    rd(12'h020, 32'h0000205F, "R4 near key");

    // Reset control while locked
    wr(12'h040, 32'h00000100, 1'b0, 1'b0, "R7 locked write");
    rd(12'h040, 32'h0, "R7 locked ignored");

    // Unlock and accepted writes
    wr(12'h020, 32'h0000A05F, 1'b0, 1'b0, "R3 key");
    rd(12'h020, 32'h0000A05F, "R3 key read");
    wr(12'h040, 32'h00000123, 1'b1, 1'b0, "R8 accepted bit8");
    rd(12'h040, 32'h00000123, "R7 accepted read");
    wr(12'h040, 32'h0000000A, 1'b0, 1'b0, "R8 accepted no bit8");
    rd(12'h040, 32'h0000000A, "R7 second accepted");

    // Overlap: pulse high while the follow-up read is accepted
    bus_sel   = 1'b1;
    bus_wr    = 1'b1;
    bus_addr  = 12'h040;
    bus_wdata = 32'h000001FF;
    @(negedge clk);
    begin
      exp_t e;
      e.value = 32'h000001FF;
      e.tag   = "R7 read right after write";
      exp_q.push_back(e);
    end
    bus_wr = 1'b0;
    check(board_rst_req == 1'b1, "R8 pulse with following read", 32'(board_rst_req), 32'h1);
    @(negedge clk);
    bus_sel = 1'b0;
    check(board_rst_req == 1'b0, "R8 pulse ends", 32'(board_rst_req), 32'h0);
    idle(1);

    // Relock, then rejected write
    wr(12'h020, 32'h00000000, 1'b0, 1'b0, "R4 relock");
    wr(12'h040, 32'h00000100, 1'b0, 1'b0, "R7 relocked write");
    rd(12'h040, 32'h000001FF, "R7 relocked unchanged");

    // Constants and undefined offsets
    rd(12'h044, 32'h00000001, "R9 pci word");
    rd(12'h050, 32'h00001000, "R9 lcd word");
    rd(12'h004, 32'h0, "R9 switch word");
    rd(12'hFFC, 32'h0, "R9 undefined");
    rd(12'h009, 32'h0, "R9 misaligned");

    // Writes to non-writable addresses
    wr(12'h000, 32'hFFFFFFFF, 1'b0, 1'b1, "R10 id write");
    wr(12'h044, 32'h00000000, 1'b0, 1'b1, "R10 pci write");
    wr(12'h050, 32'h00000000, 1'b0, 1'b1, "R10 lcd write");
    wr(12'h00C, 32'h00000055, 1'b0, 1'b1, "R10 osc write");
    wr(12'h00A, 32'h00000077, 1'b0, 1'b1, "R10 misaligned write");
    rd(12'h000, 32'h41007004, "R10 id unchanged");
    rd(12'h050, 32'h00001000, "R10 lcd unchanged");
    rd(12'h008, 32'h0000005A, "R10 led untouched");

    // Block reset alone keeps persistent flags
    idle(1);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    rd(12'h008, 32'h0, "R11 led cleared");
    rd(12'h028, 32'h0, "R11 cfg1 cleared");
    rd(12'h030, 32'h0, "R11 flags cleared");
    rd(12'h020, 32'h0, "R11 lock cleared");
    rd(12'h040, 32'h0, "R11 rstctl cleared");
    rd(12'h038, 32'h00A00010, "R11 nv flags kept");
    idle(1);
    nv_rst_n = 1'b0;
    idle(2);
    nv_rst_n = 1'b1;
    idle(1);
    rd(12'h038, 32'h0, "R11 nv flags cleared");
    rd(12'h02C, 32'h0, "R11 cfg2 cleared");
    idle(3);

    check(exp_q.size() == 0, "R12 all reads answered", 32'(exp_q.size()), 32'h0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule